// File: doc/BRIEF.md
# Power-Up Strap Latch Sequencer

This block reads the configuration straps on two dual-purpose clock pins once per power-up. While the supply-good indication is low, every register in the block stays cleared. When supply-good rises, it is brought into the reference-clock domain. A counter then runs for a fixed window measured in reference-clock cycles. Throughout that window the two pad output drivers stay three-stated, so the external pull resistors alone set the pin levels.

At the end of the window the two pad levels are captured as the frequency-select pair. The pad drivers are then enabled so the pins can carry clocks. One cycle later a ready flag rises, and downstream clock enables wait for it. The captured pair is decoded into a processor clock rate and a memory clock rate. It is held until supply-good is removed and restored. No other input can disturb it.

The default window is 28,636 cycles, which is 2 ms at a 14.318 MHz reference.

Top module: `strap_latch_seq`

## Requirements
- R1: While `pwr_good` is low, `pad_oe`, `fsel` and `ready` are all 0.
- R2: After `pwr_good` rises, `pad_oe` stays 00. It becomes 11 on the (SYNC_STAGES + WINDOW_CYCLES)-th rising edge of `clk_ref` after the rise.
- R3: On that same edge, `fsel[0]` (FS0) takes the level of `pad_in[0]` and `fsel[1]` (FS1) takes the level of `pad_in[1]`. A strap to ground gives 0 and a strap to the supply gives 1. Pad levels seen earlier in the window have no effect.
- R4: Once captured, `fsel` does not change, whatever `pad_in` does afterwards.
- R5: `ready` rises exactly one clock after `pad_oe` becomes 11, and stays high while `pwr_good` is high.
- R6: The decode from `fsel` (FS1,FS0) uses `cpu_sel` 00 = 66 MHz, 01 = 100 MHz, 10 = 133 MHz, and `mem_sel` 0 = 100 MHz, 1 = 133 MHz:
  - 00 gives CPU 66 and memory 100.
  - 01 gives CPU 100 and memory 100.
  - 10 gives CPU 133 and memory 133.
  - 11 gives CPU 133 and memory 100.
- R7: Removing and then restoring `pwr_good` reruns the whole window and captures the new pad levels.
- R8: A fall of `pwr_good` clears `pad_oe`, `fsel` and `ready` at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock that times the window |
| pwr_good | input | 1 | Supply-good indication; low clears the block asynchronously |
| pad_in | input | 2 | Levels read back from the two strap pads (bit 0 = FS0) |
| pad_oe | output | 2 | Output-driver enables of the two pads (0 = three-state) |
| fsel | output | 2 | Captured frequency-select pair (FS1,FS0) |
| cpu_sel | output | 2 | Decoded processor clock rate code |
| mem_sel | output | 1 | Decoded memory clock rate code |
| ready | output | 1 | Straps captured; downstream clock enables may open |

## Verification
Measured from the rise of `pwr_good`, the driver enable and the captured pair are due on edge SYNC_STAGES + WINDOW_CYCLES, and `ready` is due one edge later. The clear on a fall of `pwr_good` is due immediately, with no edge. The driver counts edges from the negative edge where it raises `pwr_good`. It samples one time unit after the edge concerned, checks that the enables are still off one edge before the capture, and moves the pad levels only on negative edges. On each rise of `ready`, a monitor compares `fsel` and both decoded rates against the expected entry that the driver queued from the decode table.

// File: rtl/strap_pkg.sv
package strap_pkg;
   localparam int unsigned STRAP_W = 2;

   typedef enum logic [1:0] {
      CPU_66  = 2'd0,
      CPU_100 = 2'd1,
      CPU_133 = 2'd2
   } cpu_rate_e;

   typedef enum logic {
      MEM_100 = 1'b0,
      MEM_133 = 1'b1
   } mem_rate_e;

   typedef struct packed {
      cpu_rate_e cpu;
      mem_rate_e mem;
   } rate_pair_t;

   function automatic rate_pair_t decode_fs(input logic [STRAP_W-1:0] fs);
      rate_pair_t r;
      unique case (fs)
         2'b00:   r = '{cpu: CPU_66,  mem: MEM_100};
         2'b01:   r = '{cpu: CPU_100, mem: MEM_100};
         2'b10:   r = '{cpu: CPU_133, mem: MEM_133};
         default: r = '{cpu: CPU_133, mem: MEM_100};
      endcase
      return r;
   endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic run
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign run = rst_n;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], 1'b1} & {STAGES{1'b1}};
         end
         assign run = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
   parameter int unsigned WINDOW_CYCLES = 28636
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic stop,
   output logic done
);
   localparam int unsigned CW   = $clog2(WINDOW_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

   generate
      if (WINDOW_CYCLES < 1) begin : g_bad_window
         $error("strap_window_timer: WINDOW_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          active;

   assign active = run && !stop;
   assign done   = active && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (active && !done)  cnt_q <= cnt_q + 1'b1;
   end

   // R2: the counter never passes the end of the window
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
   // R2: every active cycle short of the end advances the count by one
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !done) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/strap_capture.sv
module strap_capture
   import strap_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               win_done,
   input  logic [STRAP_W-1:0] pad_in,
   output logic [STRAP_W-1:0] fs,
   output logic               latched,
   output logic               ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs      <= '0;
         latched <= 1'b0;
         ready   <= 1'b0;
      end else begin
         if (win_done && !latched) begin
            fs      <= pad_in;
            latched <= 1'b1;
         end
         ready <= latched;
      end
   end

   // R4: the captured pair never moves once taken
   a_r4_fs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      latched |=> $stable(fs));
   // R5: ready follows the capture by one cycle
   a_r5_ready_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latched) |=> ready);
   // R5: ready is never ahead of the capture
   a_r5_ready_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> latched);
endmodule

// File: rtl/strap_latch_seq.sv
module strap_latch_seq
   import strap_pkg::*;
#(
   parameter int unsigned WINDOW_CYCLES = 28636,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic       clk_ref,
   input  logic       pwr_good,
   input  logic [1:0] pad_in,
   output logic [1:0] pad_oe,
   output logic [1:0] fsel,
   output logic [1:0] cpu_sel,
   output logic       mem_sel,
   output logic       ready
);
   generate
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("strap_latch_seq: SYNC_STAGES above 4 is not supported");
      end
   endgenerate

   logic       run;
   logic       win_done;
   logic       latched;
   rate_pair_t rates;

   strap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk_ref),
      .rst_n (pwr_good),
      .run   (run)
   );

   strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
      .clk   (clk_ref),
      .rst_n (pwr_good),
      .run   (run),
      .stop  (latched),
      .done  (win_done)
   );

   strap_capture u_cap (
      .clk      (clk_ref),
      .rst_n    (pwr_good),
      .win_done (win_done),
      .pad_in   (pad_in),
      .fs       (fsel),
      .latched  (latched),
      .ready    (ready)
   );

   assign pad_oe  = {STRAP_W{latched}};
   assign rates   = decode_fs(fsel);
   assign cpu_sel = rates.cpu;
   assign mem_sel = rates.mem;

   // R2: the pad drivers open only right after the window ends
   a_r2_oe_after_window: assert property (@(posedge clk_ref) disable iff (!pwr_good)
      $rose(pad_oe[0]) |-> $past(win_done));
   // R5: ready implies both drivers are on
   a_r5_ready_oe: assert property (@(posedge clk_ref) disable iff (!pwr_good)
      ready |-> (pad_oe == 2'b11));
   // R6: the unused processor code never appears
   a_r6_cpu_code: assert property (@(posedge clk_ref) disable iff (!pwr_good)
      cpu_sel != 2'b11);
   // R6: a 133 MHz memory rate only pairs with a 133 MHz processor rate
   a_r6_mem_pair: assert property (@(posedge clk_ref) disable iff (!pwr_good)
      mem_sel |-> (cpu_sel == 2'b10));
endmodule

// File: tb/test_strap_latch_seq.sv
module test_strap_latch_seq;
   localparam int unsigned W  = 20;
   localparam int unsigned SS = 2;

   typedef struct packed {
      logic [1:0] fs;
      logic [1:0] cpu;
      logic       mem;
   } exp_t;

   logic       clk_ref = 1'b0;
   logic       pwr_good = 1'b0;
   logic [1:0] pad_in = 2'b11;
   logic [1:0] pad_oe, fsel, cpu_sel;
   logic       mem_sel, ready;

   int checks = 0;
   int errors = 0;
   exp_t exp_q[$];

   always #10 clk_ref = ~clk_ref;

   strap_latch_seq #(.WINDOW_CYCLES(W), .SYNC_STAGES(SS)) i_strap_latch_seq (
      .clk_ref (clk_ref), .pwr_good (pwr_good), .pad_in (pad_in),
      .pad_oe (pad_oe), .fsel (fsel), .cpu_sel (cpu_sel),
      .mem_sel (mem_sel), .ready (ready)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [1:0] fs);
      exp_t e;
      e.fs = fs;
      case (fs)
         2'b00:   begin e.cpu = 2'b00; e.mem = 1'b0; end
         2'b01:   begin e.cpu = 2'b01; e.mem = 1'b0; end
         2'b10:   begin e.cpu = 2'b10; e.mem = 1'b1; end
         default: begin e.cpu = 2'b10; e.mem = 1'b0; end
      endcase
      return e;
   endfunction

   // monitor: compare decoded results whenever ready rises
   initial begin
      forever begin
         @(posedge ready);
         #1;
         if (exp_q.size() == 0) begin
            chk("R6 unexpected ready", 8'd1, 8'd0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R3 fsel", {6'd0, fsel}, {6'd0, e.fs});
            chk("R6 cpu_sel", {6'd0, cpu_sel}, {6'd0, e.cpu});
            chk("R6 mem_sel", {7'd0, mem_sel}, {7'd0, e.mem});
         end
      end
   end

   task automatic power_up(input logic [1:0] early, input logic [1:0] final_pad);
      @(negedge clk_ref);
      pwr_good = 1'b1;
      pad_in   = early;
      repeat (SS + W - 1) @(posedge clk_ref);
      #1;
      chk("R2 oe closed before window end", {6'd0, pad_oe}, 8'd0);
      chk("R5 ready low in window", {7'd0, ready}, 8'd0);
      @(negedge clk_ref);
      pad_in = final_pad;
      exp_q.push_back(model(final_pad));
      @(posedge clk_ref);
      #1;
      chk("R2 oe open at window end", {6'd0, pad_oe}, 8'h03);
      chk("R3 captured level", {6'd0, fsel}, {6'd0, final_pad});
      chk("R5 ready not yet", {7'd0, ready}, 8'd0);
      @(negedge clk_ref);
      pad_in = ~final_pad;
      @(posedge clk_ref);
      #1;
      chk("R5 ready one cycle later", {7'd0, ready}, 8'd1);
      repeat (5) @(posedge clk_ref);
      #1;
      chk("R4 fsel ignores pad", {6'd0, fsel}, {6'd0, final_pad});
      chk("R5 ready held", {7'd0, ready}, 8'd1);
   endtask

   task automatic power_down;
      @(negedge clk_ref);
      pwr_good = 1'b0;
      #1;
      chk("R8 oe cleared", {6'd0, pad_oe}, 8'd0);
      chk("R8 fsel cleared", {6'd0, fsel}, 8'd0);
      chk("R8 ready cleared", {7'd0, ready}, 8'd0);
   endtask

   initial begin
      repeat (4) @(posedge clk_ref);
      #1;
      chk("R1 oe in reset", {6'd0, pad_oe}, 8'd0);
      chk("R1 fsel in reset", {6'd0, fsel}, 8'd0);
      chk("R1 ready in reset", {7'd0, ready}, 8'd0);
      // R7: each power cycle reruns the window and takes new straps
      power_up(2'b11, 2'b00);
      power_down();
      power_up(2'b10, 2'b01);
      power_down();
      power_up(2'b01, 2'b10);
      power_down();
      power_up(2'b00, 2'b11);
      power_down();
      repeat (3) @(posedge clk_ref);
      #1;
      chk("R1 stays cleared", {7'd0, ready}, 8'd0);
      chk("R6 all results consumed", 8'(exp_q.size()), 8'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule